// File: doc/BRIEF.md
# Redundant Control Word Decoder

This block sits on the receive side of a serial video link, after word alignment. Each input word is 20 bits wide and arrives with a strobe and a two-bit type tag. The tag marks the word as video, control or transition. From these words the block rebuilds three parallel outputs: an 18-bit video bus, a 9-bit control bus and a data-enable flag.

Video words carry a two-bit code that tells the block whether the sender inverted the 18 symbols. The block undoes that inversion. Control words carry each of the five low control bits three times, and the block resolves each of them by majority vote. It also reports, one group at a time, where the copies did not agree, so that single-bit line errors can be counted.

Each output group changes only when a word of its own kind arrives. Between such words it holds its value, so the video bus is steady across blanking and the control bus is steady across active video.

Top module: `lnk_word_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all outputs are zero after that edge, so `de_o` starts in the control phase.
- R2: For a control word (`word_kind_i` = 2'b00), each control bit `ctl_o[g]` with g from 0 to 4 takes the majority value of word bits 1+3g, 2+3g and 3+3g. This means one flipped copy in a group is corrected.
- R3: For a control word, `ctl_o[5]` through `ctl_o[8]` take word bits 16 through 19 directly, with no voting.
- R4: After a control word, `vote_fix_o[g]` is 1 for exactly one cycle when the three copies of group g are not all equal. Otherwise it is 0.
- R5: For a video word (`word_kind_i` = 2'b01) whose bits {1,0} are 2'b01, `vid_o` becomes word bits 19 to 2 unchanged.
- R6: For a video word whose bits {1,0} are 2'b10, `vid_o` becomes the bitwise inverse of word bits 19 to 2.
- R7: For a video word whose bits {1,0} are 2'b00 or 2'b11, `code_err_o` pulses for one cycle, and `vid_o` and `de_o` keep their values.
- R8: `de_o` becomes 1 after an accepted video word and 0 after a control word. It is unchanged after a transition word (`word_kind_i` of 2'b10 or 2'b11) and while `word_vld_i` is low.
- R9: `ctl_o` holds its value through video words, transition words and cycles with `word_vld_i` low.
- R10: `vid_o` holds its value through control words, transition words and cycles with `word_vld_i` low.
- R11: Every output reflects the word sampled at a rising edge right after that edge, with one register stage of latency. `code_err_o` and `vote_fix_o` are zero in any cycle that does not follow a word of the matching kind.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_vld_i | input | 1 | Word strobe |
| word_kind_i | input | 2 | 00 control, 01 video, 10/11 transition |
| word_i | input | 20 | Aligned word, bit 0 first on the line |
| vid_o | output | 18 | Recovered video symbols |
| ctl_o | output | 9 | Recovered control bits |
| de_o | output | 1 | Data enable, 1 in the video phase |
| code_err_o | output | 1 | One-cycle pulse for an illegal video code |
| vote_fix_o | output | 5 | Per-group flag for copies that disagreed |

## Verification
The bench builds the block with its default parameters: an 18-bit video field, 9 control bits, 5 voted groups and 3 copies per group. With three copies, all eight copy patterns of every group can be reached in a single word. This covers the case of one corrected copy, the case of two flipped copies that overturn the vote, and the unanimous case that leaves the repair flag low. The 20-bit word also leaves room for all four code values on video words, so both legal codes and both illegal codes are exercised together with phase changes in both directions.

// File: rtl/lnk_dec_pkg.sv
// Package: shared word-kind encoding and video code values for the word decoder.
// Assumes the kind tag is produced by an upstream aligner alongside each word.
package lnk_dec_pkg;

    typedef enum logic [1:0] {
        WK_CTRL    = 2'b00,
        WK_VIDEO   = 2'b01,
        WK_TRANS_A = 2'b10,
        WK_TRANS_B = 2'b11
    } word_kind_e;

    // Two-bit code in the low bits of a video word, read as {bit1, bit0}.
    localparam logic [1:0] VCODE_PLAIN  = 2'b01;
    localparam logic [1:0] VCODE_INVERT = 2'b10;

endpackage

// File: rtl/lnk_vote_bank.sv
// Module: majority resolution of the repeated control bits of a control word.
// Input is the word with its lowest (unused) bit removed: GROUPS fields of
// COPIES bits each, followed by SINGLES unprotected bits. Purely combinational.
// Assumes COPIES is odd so that a strict majority always exists.
module lnk_vote_bank #(
    parameter int GROUPS  = 5,
    parameter int COPIES  = 3,
    parameter int SINGLES = 4,
    parameter int FIELD_W = GROUPS * COPIES + SINGLES
) (
    input  logic [FIELD_W-1:0]        field_i,
    output logic [GROUPS+SINGLES-1:0] bits_o,
    output logic [GROUPS-1:0]         split_o
);

    localparam int HALF = COPIES / 2;

    // One voter per protected group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_voter
        logic [COPIES-1:0] copies_w;
        assign copies_w   = field_i[g*COPIES +: COPIES];
        // Majority: more than half of the copies are set.
        assign bits_o[g]  = ($countones(copies_w) > HALF);
        // Disagreement: neither all-zero nor all-one.
        assign split_o[g] = (copies_w != '0) && (copies_w != '1);
    end

    // Unprotected bits pass straight through.
    for (genvar s = 0; s < SINGLES; s++) begin : g_single
        assign bits_o[GROUPS+s] = field_i[GROUPS*COPIES + s];
    end

endmodule

// File: rtl/lnk_video_restore.sv
// Module: removes the sender's optional inversion from a video word.
// Bits {1,0} hold the code; the symbols sit above them. Codes other than the
// two legal ones are flagged through bad_code_o. Purely combinational.
module lnk_video_restore
    import lnk_dec_pkg::*;
#(
    parameter int VID_W  = 18,
    parameter int WORD_W = VID_W + 2
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [VID_W-1:0]  sym_o,
    output logic              bad_code_o
);

    logic [1:0]       code_w;
    logic [VID_W-1:0] raw_w;

    assign code_w = word_i[1:0];
    assign raw_w  = word_i[WORD_W-1:2];

    // Select plain or inverted symbols; flag illegal codes.
    always_comb begin
        sym_o      = raw_w;
        bad_code_o = 1'b0;
        unique case (code_w)
            VCODE_PLAIN:  sym_o = raw_w;
            VCODE_INVERT: sym_o = ~raw_w;
            default:      bad_code_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/lnk_dec_regs.sv
// Module: output state of the decoder. Each output group loads only on a
// word of its own kind and otherwise holds its value. Event flags last one cycle.
// Assumes a synchronous active-low reset.
module lnk_dec_regs
    import lnk_dec_pkg::*;
#(
    parameter int VID_W  = 18,
    parameter int CTL_W  = 9,
    parameter int GROUPS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [1:0]        kind_i,
    input  logic [VID_W-1:0]  sym_i,
    input  logic              bad_code_i,
    input  logic [CTL_W-1:0]  ctl_bits_i,
    input  logic [GROUPS-1:0] split_i,
    output logic [VID_W-1:0]  vid_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              de_o,
    output logic              err_o,
    output logic [GROUPS-1:0] fix_o
);

    logic is_vid_w;
    logic is_ctl_w;
    logic vid_ok_w;

    assign is_vid_w = vld_i && (kind_i == WK_VIDEO);
    assign is_ctl_w = vld_i && (kind_i == WK_CTRL);
    assign vid_ok_w = is_vid_w && !bad_code_i;

    // Video bus: refreshed only by a video word with a legal code.
    always_ff @(posedge clk) begin
        if (!rst_n)        vid_o <= '0;
        else if (vid_ok_w) vid_o <= sym_i;
    end

    // Control bus: refreshed only by a control word.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_o <= '0;
        else if (is_ctl_w) ctl_o <= ctl_bits_i;
    end

    // Phase flag: set by accepted video, cleared by control, else held.
    always_ff @(posedge clk) begin
        if (!rst_n)        de_o <= 1'b0;
        else if (vid_ok_w) de_o <= 1'b1;
        else if (is_ctl_w) de_o <= 1'b0;
    end

    // One-cycle event flags for illegal codes and repaired groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
            fix_o <= '0;
        end else begin
            err_o <= is_vid_w && bad_code_i;
            fix_o <= is_ctl_w ? split_i : '0;
        end
    end

endmodule

// File: rtl/lnk_word_decoder.sv
// Module: top of the receive word decoder. Feeds each word to the video
// restorer and the vote bank in parallel, then registers the results
// according to the word kind. Assumes words arrive already aligned.
module lnk_word_decoder
    import lnk_dec_pkg::*;
#(
    parameter int VID_W       = 18,
    parameter int CTL_W       = 9,
    parameter int VOTE_GRPS   = 5,
    parameter int VOTE_COPIES = 3,
    parameter int WORD_W      = VID_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_vld_i,
    input  logic [1:0]           word_kind_i,
    input  logic [WORD_W-1:0]    word_i,
    output logic [VID_W-1:0]     vid_o,
    output logic [CTL_W-1:0]     ctl_o,
    output logic                 de_o,
    output logic                 code_err_o,
    output logic [VOTE_GRPS-1:0] vote_fix_o
);

    localparam int SINGLE_W = CTL_W - VOTE_GRPS;
    localparam int FIELD_W  = WORD_W - 1;

    logic [VID_W-1:0]     sym_w;
    logic                 bad_w;
    logic [CTL_W-1:0]     ctl_bits_w;
    logic [VOTE_GRPS-1:0] split_w;

    lnk_video_restore #(
        .VID_W  (VID_W),
        .WORD_W (WORD_W)
    ) u_restore (
        .word_i     (word_i),
        .sym_o      (sym_w),
        .bad_code_o (bad_w)
    );

    lnk_vote_bank #(
        .GROUPS  (VOTE_GRPS),
        .COPIES  (VOTE_COPIES),
        .SINGLES (SINGLE_W),
        .FIELD_W (FIELD_W)
    ) u_vote (
        .field_i (word_i[WORD_W-1:1]),
        .bits_o  (ctl_bits_w),
        .split_o (split_w)
    );

    lnk_dec_regs #(
        .VID_W  (VID_W),
        .CTL_W  (CTL_W),
        .GROUPS (VOTE_GRPS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (word_vld_i),
        .kind_i     (word_kind_i),
        .sym_i      (sym_w),
        .bad_code_i (bad_w),
        .ctl_bits_i (ctl_bits_w),
        .split_i    (split_w),
        .vid_o      (vid_o),
        .ctl_o      (ctl_o),
        .de_o       (de_o),
        .err_o      (code_err_o),
        .fix_o      (vote_fix_o)
    );

endmodule

// File: rtl/lnk_word_decoder_chk.sv
// Module: temporal checks on the decoder ports, attached with bind below.
module lnk_word_decoder_chk #(
    parameter int VID_W     = 18,
    parameter int CTL_W     = 9,
    parameter int VOTE_GRPS = 5,
    parameter int WORD_W    = VID_W + 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 word_vld_i,
    input logic [1:0]           word_kind_i,
    input logic [WORD_W-1:0]    word_i,
    input logic [VID_W-1:0]     vid_o,
    input logic [CTL_W-1:0]     ctl_o,
    input logic                 de_o,
    input logic                 code_err_o,
    input logic [VOTE_GRPS-1:0] vote_fix_o
);

    logic vid_in, ctl_in, bad_in;
    assign vid_in = word_vld_i && (word_kind_i == 2'b01);
    assign ctl_in = word_vld_i && (word_kind_i == 2'b00);
    assign bad_in = (word_i[1:0] == 2'b00) || (word_i[1:0] == 2'b11);

    AST_VID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_in |=> $stable(vid_o)); // R10
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_in |=> $stable(ctl_o)); // R9
    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_in && word_i[1:0] == 2'b01) |=> (vid_o == $past(word_i[WORD_W-1:2]))); // R5
    AST_INV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_in && word_i[1:0] == 2'b10) |=> (vid_o == ~$past(word_i[WORD_W-1:2]))); // R6
    AST_BAD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_in && bad_in) |=> (code_err_o && $stable(vid_o) && $stable(de_o))); // R7
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |-> $past(vid_in)); // R11
    AST_DE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_in |=> !de_o); // R8
    AST_DE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_in && !bad_in) |=> de_o); // R8
    AST_FIX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_fix_o != '0) |-> $past(ctl_in)); // R4

endmodule

bind lnk_word_decoder lnk_word_decoder_chk #(
    .VID_W     (VID_W),
    .CTL_W     (CTL_W),
    .VOTE_GRPS (VOTE_GRPS),
    .WORD_W    (WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_vld_i  (word_vld_i),
    .word_kind_i (word_kind_i),
    .word_i      (word_i),
    .vid_o       (vid_o),
    .ctl_o       (ctl_o),
    .de_o        (de_o),
    .code_err_o  (code_err_o),
    .vote_fix_o  (vote_fix_o)
);

// File: tb/lnk_word_decoder_tb.sv
module lnk_word_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [19:0] word = '0;
    logic [17:0] vid;
    logic [8:0]  ctl;
    logic        de, err;
    logic [4:0]  fix;

    int n_chk = 0;
    int n_bad = 0;

    // Expected values for the next compare, with requirement tags.
    logic [17:0] e_vid = '0;
    logic [8:0]  e_ctl = '0;
    logic        e_de = 1'b0, e_err = 1'b0;
    logic [4:0]  e_fix = '0;
    string t_vid = "R1", t_ctl = "R1", t_de = "R1", t_err = "R1", t_fix = "R1";

    always #2 clk = ~clk;

    lnk_word_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .word_vld_i(vld), .word_kind_i(kind),
        .word_i(word), .vid_o(vid), .ctl_o(ctl), .de_o(de),
        .code_err_o(err), .vote_fix_o(fix)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare outputs, then apply one cycle of stimulus and advance the model.
    task automatic step(input logic r, input logic v, input logic [1:0] k,
                        input logic [19:0] w);
        @(negedge clk);
        chk(t_vid, "vid_o", 32'(vid), 32'(e_vid));
        chk(t_ctl, "ctl_o", 32'(ctl), 32'(e_ctl));
        chk(t_de,  "de_o",  32'(de),  32'(e_de));
        chk(t_err, "code_err_o", 32'(err), 32'(e_err));
        chk(t_fix, "vote_fix_o", 32'(fix), 32'(e_fix));
        rst_n = r; vld = v; kind = k; word = w;
        if (!r) begin // R1
            e_vid = '0; e_ctl = '0; e_de = 0; e_err = 0; e_fix = '0;
            t_vid = "R1"; t_ctl = "R1"; t_de = "R1"; t_err = "R1"; t_fix = "R1";
        end else begin
            // Event flags are zero unless this word raises them (R11).
            e_err = 0; e_fix = '0; t_err = "R11"; t_fix = "R11";
            t_vid = "R10"; t_ctl = "R9"; t_de = "R8";
            if (v && k == 2'b01) begin
                if (w[1:0] == 2'b01) begin
                    e_vid = w[19:2]; e_de = 1; t_vid = "R5";
                end else if (w[1:0] == 2'b10) begin
                    e_vid = ~w[19:2]; e_de = 1; t_vid = "R6";
                end else begin
                    e_err = 1; t_err = "R7"; t_vid = "R7"; t_de = "R7";
                end
            end else if (v && k == 2'b00) begin
                for (int g = 0; g < 5; g++) begin
                    int ones = 0;
                    for (int c = 0; c < 3; c++) ones += w[1 + 3*g + c];
                    e_ctl[g] = (ones >= 2);
                    e_fix[g] = (ones == 1) || (ones == 2);
                end
                for (int j = 0; j < 4; j++) e_ctl[5+j] = w[16+j];
                e_de = 0; t_ctl = "R2 R3"; t_fix = "R4";
            end
        end
    endtask

    function automatic logic [19:0] mk_ctl(input logic [8:0] c, input logic [14:0] flip);
        logic [19:0] w = '0;
        for (int g = 0; g < 5; g++)
            for (int k = 0; k < 3; k++) w[1 + 3*g + k] = c[g] ^ flip[3*g + k];
        for (int j = 0; j < 4; j++) w[16+j] = c[5+j];
        return w;
    endfunction

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset with busy inputs.
        for (int i = 0; i < 3; i++) step(0, 1, 2'b01, 20'hABCD1);
        step(1, 0, 2'b00, '0);
        step(1, 0, 2'b00, '0);
        // R2 R3: clean control word, then single flips in each group (R4).
        step(1, 1, 2'b00, mk_ctl(9'h1B5, 15'h0));
        step(1, 1, 2'b00, mk_ctl(9'h0AA, 15'b001_010_100_001_010));
        // Two flips in group 0 overturn the vote (R2).
        step(1, 1, 2'b00, mk_ctl(9'h1FF, 15'b000_000_000_000_011));
        // R5 R6: plain and inverted video; R9: control held.
        step(1, 1, 2'b01, {18'h2A5C3, 2'b01});
        step(1, 1, 2'b01, {18'h0F0F0, 2'b10});
        // R7: illegal codes keep video and de.
        step(1, 1, 2'b01, {18'h3FFFF, 2'b00});
        step(1, 1, 2'b01, {18'h12345, 2'b11});
        // R8 R10: transition words and idle hold everything.
        step(1, 1, 2'b10, 20'hFFFFF);
        step(1, 1, 2'b11, 20'h5A5A5);
        step(1, 0, 2'b01, {18'h11111, 2'b01});
        step(1, 1, 2'b00, mk_ctl(9'h100, 15'h7FFF));
        // Illegal code right after control: de stays low (R7).
        step(1, 1, 2'b01, {18'h00001, 2'b11});
        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 99);
            logic [19:0] w = 20'($urandom);
            if (sel < 15)      step(1, 0, 2'($urandom), w);
            else if (sel < 50) step(1, 1, 2'b00, w);
            else if (sel < 85) begin
                if ($urandom_range(0, 9) != 0) w[1:0] = $urandom_range(0, 1) ? 2'b01 : 2'b10;
                step(1, 1, 2'b01, w);
            end else           step(1, 1, $urandom_range(0, 1) ? 2'b10 : 2'b11, w);
            if (i == 1500) step(0, 1, 2'b01, {18'h3C3C3, 2'b01}); // R1 mid-run
        end
        step(1, 0, 2'b00, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule